// File: doc/BRIEF.md
# GPIO Interrupt Bank

A bank of general-purpose pins that sits behind a simple register port. Every pin has three bits: one for output data, one for output enable and one for the sampled input. Software drives a pin by setting its enable bit, and it can read any pin back through the synchronised input register.

Any pin can also raise an interrupt. A per-pin select bit connects the pin to the detector. Two further bit-planes choose the trigger: one picks edge or level and the other picks polarity. Detected events set sticky status bits. Status is masked by a per-pin enable and collapsed onto two interrupt lines, one for the lower half of the bank and one for the upper half.

Every writable register takes a full write, a write that only sets bits, or a write that only clears bits. This lets several agents change single pins without a read-modify-write. Status can only be cleared, and only through its clear address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pad_out_o` and `pad_oe_o` are 0, and both interrupt lines are low.
- R2: `reg_addr_i[4:2]` selects the register: 0 output data, 1 input data, 2 output enable, 3 interrupt select, 4 interrupt enable, 5 level mode, 6 polarity, 7 status. `reg_addr_i[1:0]` selects the write kind: 0 full write, 1 set, 2 clear, 3 no effect. `reg_rdata_o` returns the selected register combinationally, whatever the write kind bits are.
- R3: A set write ORs the data into the register and a clear write clears the bits that are 1 in the data. All other bits keep their value.
- R4: `pad_out_o` and `pad_oe_o` show the output data and output enable registers from the clock edge that accepts the write.
- R5: The input data register holds `pad_in_i` delayed by a two-flop synchroniser. A pin change made before clock edge k is readable after edge k+1. Writes to this register have no effect.
- R6: The trigger of a pin is {polarity, level}: 00 falling edge, 01 low level, 10 rising edge, 11 high level.
- R7: An edge on a selected pin that is made before edge k sets its status bit at edge k+2. An edge-mode status bit stays set until it is cleared.
- R8: In level mode the status bit stays set while the level persists. After a clear it reads 0 for one cycle and then sets again if the level is still present.
- R9: A pin whose interrupt select bit is 0 never sets its status bit.
- R10: Status bits are cleared only by the clear-kind write to register 7. Full and set writes to status have no effect. When a clear and a detection hit the same bit in the same cycle, the clear wins.
- R11: `irq_lo_o` is the OR of status AND enable over pins 0 to 15, and `irq_hi_o` is the same over pins 16 to 31. With `SPLIT_IRQ` = 0, all pins drive `irq_lo_o` and `irq_hi_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register index and write kind |
| reg_wdata_i | input | W | Write data, one bit per pin |
| reg_rdata_o | output | W | Read data of the addressed register |
| pad_in_i | input | W | Pin levels, asynchronous |
| pad_out_o | output | W | Output data to the pads |
| pad_oe_o | output | W | Output enable to the pads |
| irq_lo_o | output | 1 | Interrupt for the lower half of the bank (or the whole bank) |
| irq_hi_o | output | 1 | Interrupt for the upper half of the bank |

## Verification
The assertions assume the register port carries known values with at most one write per cycle. They also assume the pins are sampled only through the synchroniser, so the status checks look one edge back and never at `pad_in_i` directly. The stimulus changes the pins and the register port only on the falling clock edge, and only with defined values. It mixes directed trigger scenarios with long random runs, in which pins toggle at random and writes of every kind land on all eight registers, including the read-only ones and status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    REG_DOUT = 3'd0,
    REG_DIN  = 3'd1,
    REG_OE   = 3'd2,
    REG_SEL  = 3'd3,
    REG_EN   = 3'd4,
    REG_LEV  = 3'd5,
    REG_POL  = 3'd6,
    REG_STAT = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    WR_FULL = 2'd0,
    WR_SET  = 2'd1,
    WR_CLR  = 2'd2,
    WR_NONE = 2'd3
  } wr_kind_e;

  // plain control registers, in storage order
  localparam int NUM_CTL = 6;

  function automatic reg_idx_e ctl_reg(int k);
    case (k)
      0:       return REG_DOUT;
      1:       return REG_OE;
      2:       return REG_SEL;
      3:       return REG_EN;
      4:       return REG_LEV;
      default: return REG_POL;
    endcase
  endfunction

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  wr_kind_e     kind_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (wr_i) begin
      case (kind_i)
        WR_FULL: q <= wdata_i;
        WR_SET:  q <= q | wdata_i;
        WR_CLR:  q <= q & ~wdata_i;
        default: q <= q;
      endcase
    end
  end

  assign q_o = q;

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] lev_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] stat_q;
  logic [W-1:0] raw;
  logic [W-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  // {pol,lev}: 00 fall, 01 low, 10 rise, 11 high
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign raw[i] = lev_i[i] ? ~(cur_i[i] ^ pol_i[i])
                  : (pol_i[i] ? (cur_i[i] & ~prev_q[i]) : (prev_q[i] & ~cur_i[i]));
  end

  assign hit = raw & sel_i;

  // clear dominates a same-cycle hit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q | hit) & ~clr_i;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit SPLIT_IRQ   = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reg_we_i,
  input  logic [4:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic         irq_lo_o,
  output logic         irq_hi_o
);

  localparam int HALF = W / 2;

  reg_idx_e     idx;
  wr_kind_e     kind;
  logic [W-1:0] ctl_q [NUM_CTL];
  logic [W-1:0] dout_q, oe_q, sel_q, en_q, lev_q, pol_q;
  logic [W-1:0] din_q, stat_q, clr_mask, pend;

  assign idx  = reg_idx_e'(reg_addr_i[4:2]);
  assign kind = wr_kind_e'(reg_addr_i[1:0]);

  for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
    gpio_alias_reg #(.W(W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (reg_we_i && (idx == ctl_reg(k))),
      .kind_i (kind),
      .wdata_i(reg_wdata_i),
      .q_o    (ctl_q[k])
    );
  end

  assign dout_q = ctl_q[0];
  assign oe_q   = ctl_q[1];
  assign sel_q  = ctl_q[2];
  assign en_q   = ctl_q[3];
  assign lev_q  = ctl_q[4];
  assign pol_q  = ctl_q[5];

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (din_q)
  );

  assign clr_mask = (reg_we_i && idx == REG_STAT && kind == WR_CLR) ? reg_wdata_i : '0;

  gpio_irq_detect #(.W(W)) u_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cur_i (din_q),
    .sel_i (sel_q),
    .lev_i (lev_q),
    .pol_i (pol_q),
    .clr_i (clr_mask),
    .stat_o(stat_q)
  );

  always_comb begin
    case (idx)
      REG_DOUT: reg_rdata_o = dout_q;
      REG_DIN:  reg_rdata_o = din_q;
      REG_OE:   reg_rdata_o = oe_q;
      REG_SEL:  reg_rdata_o = sel_q;
      REG_EN:   reg_rdata_o = en_q;
      REG_LEV:  reg_rdata_o = lev_q;
      REG_POL:  reg_rdata_o = pol_q;
      default:  reg_rdata_o = stat_q;
    endcase
  end

  assign pad_out_o = dout_q;
  assign pad_oe_o  = oe_q;
  assign pend      = stat_q & en_q;

  if (SPLIT_IRQ) begin : g_split
    assign irq_lo_o = |pend[HALF-1:0];
    assign irq_hi_o = |pend[W-1:HALF];
  end else begin : g_single
    assign irq_lo_o = |pend;
    assign irq_hi_o = 1'b0;
  end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         reg_we_i,
  input logic [4:0]   reg_addr_i,
  input logic [W-1:0] reg_wdata_i,
  input logic [W-1:0] pad_out_o,
  input logic [W-1:0] pad_oe_o,
  input logic         irq_lo_o,
  input logic         irq_hi_o,
  input logic [W-1:0] stat_q,
  input logic [W-1:0] en_q,
  input logic [W-1:0] sel_q,
  input logic [W-1:0] lev_q
);

  logic         stat_clr_wr, dout_full_wr, oe_set_wr;
  logic [W-1:0] clr_seen;

  assign stat_clr_wr  = reg_we_i && reg_addr_i == {REG_STAT, WR_CLR};
  assign dout_full_wr = reg_we_i && reg_addr_i == {REG_DOUT, WR_FULL};
  assign oe_set_wr    = reg_we_i && reg_addr_i == {REG_OE, WR_SET};
  assign clr_seen     = stat_clr_wr ? reg_wdata_i : '0;

  assert_full_write_drives_pad_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_full_wr |=> pad_out_o == $past(reg_wdata_i));

  assert_set_alias_keeps_others_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_set_wr |=> ((pad_oe_o & $past(reg_wdata_i)) == $past(reg_wdata_i)) &&
                  ((pad_oe_o & ~$past(reg_wdata_i)) == ($past(pad_oe_o) & ~$past(reg_wdata_i))));

  assert_clear_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_wr |=> (stat_q & $past(reg_wdata_i)) == '0);

  assert_unselected_never_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_q & ~$past(stat_q) & ~$past(sel_q)) == '0);

  assert_edge_status_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(stat_q) & ~$past(lev_q) & ~$past(clr_seen)) & ~stat_q) == '0);

  assert_masked_no_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> (!irq_lo_o && !irq_hi_o));

endmodule

bind gpio_irq_bank gpio_bank_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .pad_out_o  (pad_out_o),
  .pad_oe_o   (pad_oe_o),
  .irq_lo_o   (irq_lo_o),
  .irq_hi_o   (irq_hi_o),
  .stat_q     (stat_q),
  .en_q       (en_q),
  .sel_q      (sel_q),
  .lev_q      (lev_q)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         we = 1'b0;
  logic [4:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] pad = '0;
  logic [W-1:0] rdata, pad_out, pad_oe;
  logic         irq_lo, irq_hi;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.W(W)) i_gpio_irq_bank (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pad_in_i(pad),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [W-1:0] m_reg [8];
  logic [W-1:0] hist [$];

  always @(posedge clk or negedge rst_ni) begin : model
    logic [W-1:0] cur, prv, hit, clr;
    if (!rst_ni) begin
      for (int r = 0; r < 8; r++) m_reg[r] = '0;
      hist = '{'0, '0, '0};
    end else begin
      cur = hist[1];
      prv = hist[2];
      for (int i = 0; i < W; i++) begin
        hit[i] = 1'b0;
        if (m_reg[3][i]) begin
          case ({m_reg[6][i], m_reg[5][i]})
            2'b00: hit[i] = prv[i] && !cur[i];
            2'b01: hit[i] = !cur[i];
            2'b10: hit[i] = cur[i] && !prv[i];
            default: hit[i] = cur[i];
          endcase
        end
      end
      clr = (we && addr[4:2] == 3'd7 && addr[1:0] == 2'd2) ? wdata : '0;
      m_reg[7] = (m_reg[7] | hit) & ~clr;
      if (we && addr[4:2] != 3'd1 && addr[4:2] != 3'd7) begin
        case (addr[1:0])
          2'd0: m_reg[addr[4:2]] = wdata;
          2'd1: m_reg[addr[4:2]] = m_reg[addr[4:2]] | wdata;
          2'd2: m_reg[addr[4:2]] = m_reg[addr[4:2]] & ~wdata;
          default: ;
        endcase
      end
      hist.push_front(pad);
      void'(hist.pop_back());
      m_reg[1] = hist[1];
    end
  end

  always @(negedge clk) begin : compare
    logic [W-1:0] pend;
    #1;
    if (rst_ni && !done) begin
      pend = m_reg[7] & m_reg[4];
      chk("R4", "pad_out_o", pad_out, m_reg[0]);
      chk("R4", "pad_oe_o", pad_oe, m_reg[2]);
      chk("R11", "irq_lo_o", {31'd0, irq_lo}, {31'd0, |pend[15:0]});
      chk("R11", "irq_hi_o", {31'd0, irq_hi}, {31'd0, |pend[31:16]});
      chk("R2", "reg_rdata_o", rdata, m_reg[addr[4:2]]);
    end
  end

  // ---------------- drivers ----------------
  task automatic wr(logic [2:0] r, logic [1:0] k, logic [W-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = {r, k}; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // call at a falling edge; samples the combinational read
  task automatic rd(logic [2:0] r, logic [1:0] k, output logic [W-1:0] d);
    addr = {r, k};
    #1 d = rdata;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin : watchdog
    #400000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin : main
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int r = 0; r < 8; r++) begin
      rd(r[2:0], 2'd0, v);
      chk("R1", "register after reset", v, '0);
    end
    chk("R1", "pad_oe_o after reset", pad_oe, '0);
    chk("R1", "irq after reset", {30'd0, irq_hi, irq_lo}, '0);

    // R2, R3: write kinds
    wr(3'd0, 2'd0, 32'hA5A5_0F0F);
    wr(3'd0, 2'd1, 32'h0000_00F0);
    rd(3'd0, 2'd0, v); chk("R3", "set alias", v, 32'hA5A5_0FFF);
    wr(3'd0, 2'd2, 32'hA000_0000);
    rd(3'd0, 2'd0, v); chk("R3", "clear alias", v, 32'h05A5_0FFF);
    wr(3'd0, 2'd3, 32'hFFFF_FFFF);
    rd(3'd0, 2'd2, v); chk("R2", "kind 3 ignored, read via clear address", v, 32'h05A5_0FFF);
    chk("R4", "pad_out_o follows output data", pad_out, 32'h05A5_0FFF);
    wr(3'd2, 2'd0, 32'h0000_FFFF);
    chk("R4", "pad_oe_o follows enable", pad_oe, 32'h0000_FFFF);

    // R5: synchroniser delay
    pad = 32'h1234_5678;
    @(negedge clk);
    rd(3'd1, 2'd0, v); chk("R5", "input one edge after change", v, '0);
    @(negedge clk);
    rd(3'd1, 2'd0, v); chk("R5", "input two edges after change", v, 32'h1234_5678);
    wr(3'd1, 2'd0, 32'hFFFF_FFFF);
    rd(3'd1, 2'd0, v); chk("R5", "input register write ignored", v, 32'h1234_5678);

    // trigger setup: bit3 rise, bit4 fall, bit5 low level, bit20 high level, bit6 unselected rise
    pad = 32'h0000_0030;
    repeat (4) @(negedge clk);
    wr(3'd5, 2'd0, 32'h0010_0020);
    wr(3'd6, 2'd0, 32'h0010_0048);
    wr(3'd4, 2'd0, 32'hFFFF_FFFF);
    wr(3'd3, 2'd0, 32'h0010_0038);
    repeat (3) @(negedge clk);
    rd(3'd7, 2'd0, v); chk("R9", "no status before any event", v, '0);

    // R7: rising edge latency
    pad = pad | 32'h0000_0048;
    @(negedge clk);
    rd(3'd7, 2'd0, v); chk("R7", "status after edge k", v, '0);
    @(negedge clk);
    rd(3'd7, 2'd0, v); chk("R7", "status after edge k+1", v, '0);
    @(negedge clk);
    rd(3'd7, 2'd0, v); chk("R7", "status after edge k+2, bit6 unselected (R9)", v, 32'h0000_0008);
    chk("R11", "irq_lo_o on low-half event", {31'd0, irq_lo}, 32'd1);
    pad = pad & ~32'h0000_0048;
    repeat (4) @(negedge clk);
    rd(3'd7, 2'd0, v); chk("R7", "edge status sticky", v, 32'h0000_0008);
    wr(3'd7, 2'd2, 32'h0000_0008);
    rd(3'd7, 2'd0, v); chk("R10", "clear alias on status", v, '0);

    // R6: falling edge, R10: full and set writes ignored
    pad = pad & ~32'h0000_0010;
    repeat (4) @(negedge clk);
    rd(3'd7, 2'd0, v); chk("R6", "falling edge mode", v, 32'h0000_0010);
    wr(3'd7, 2'd0, 32'h0000_0000);
    rd(3'd7, 2'd0, v); chk("R10", "full write to status ignored", v, 32'h0000_0010);
    wr(3'd7, 2'd1, 32'hFFFF_FFFF);
    rd(3'd7, 2'd0, v); chk("R10", "set write to status ignored", v, 32'h0000_0010);
    wr(3'd7, 2'd2, 32'h0000_0010);

    // R6 low level, R8 re-set after clear
    pad = pad & ~32'h0000_0020;
    repeat (4) @(negedge clk);
    rd(3'd7, 2'd0, v); chk("R6", "low level mode", v, 32'h0000_0020);
    wr(3'd7, 2'd2, 32'h0000_0020);
    rd(3'd7, 2'd0, v); chk("R8", "level status cleared for one cycle", v, '0);
    @(negedge clk);
    rd(3'd7, 2'd0, v); chk("R8", "level status sets again", v, 32'h0000_0020);
    pad = pad | 32'h0000_0020;
    repeat (3) @(negedge clk);
    wr(3'd7, 2'd2, 32'h0000_0020);
    repeat (2) @(negedge clk);
    rd(3'd7, 2'd0, v); chk("R8", "level gone, stays clear", v, '0);

    // R11: upper half line and masking
    pad = pad | 32'h0010_0000;
    repeat (3) @(negedge clk);
    chk("R11", "irq_hi_o on high-level pin 20", {30'd0, irq_hi, irq_lo}, 32'd2);
    wr(3'd4, 2'd2, 32'h0010_0000);
    chk("R11", "enable cleared masks irq_hi_o", {31'd0, irq_hi}, '0);
    rd(3'd7, 2'd0, v); chk("R11", "status kept while masked", v, 32'h0010_0000);
    wr(3'd4, 2'd1, 32'h0010_0000);
    pad = pad & ~32'h0010_0000;
    repeat (3) @(negedge clk);
    wr(3'd7, 2'd2, 32'hFFFF_FFFF);

    // random phase, compared against the model every cycle
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      we    = ($urandom % 4) == 0;
      addr  = 5'($urandom);
      wdata = $urandom;
      if (($urandom % 6) == 0) pad = pad ^ (32'd1 << ($urandom % 32));
    end
    @(negedge clk);
    we = 1'b0;
    repeat (4) @(negedge clk);
    finish_up();
  end

endmodule